// File: doc/BRIEF.md
# Flash Protected-Range Guard

This block sits beside a serial flash cycle engine and judges every flash access before the engine runs it. It holds five range registers, and each register names a span of 4 KiB pages. Each range has its own write-protect enable, which also covers erase, and its own read-protect enable. An access presents an address, a kind and a valid strobe. One cycle later the block reports whether the access may go ahead. A refused access raises a one-cycle error pulse and sets a sticky error flag.

The host programs the ranges through a small register port. Ranges are only enforced once the host sets a lock-down bit. From then on the range registers refuse all writes, and the lock itself cannot be cleared until reset. Before the lock is set, every access is allowed. This lets firmware build up the table in any order and then freeze it in one step.

Top module: `flash_range_guard`

## Requirements
- R1: After reset all five range registers read 0, the lock reads 0, the error flag is 0, res_valid is 0 and err_pulse is 0.
- R2: Range register n sits at reg_addr n, for n from 0 to 4. Bit 31 is the write/erase enable. Bits 28:16 hold the upper page number (flash address bits 24:12). Bit 15 is the read enable. Bits 12:0 hold the lower page number. Bits 30:29 and 14:13 read as 0 whatever is written to them.
- R3: Writing 1 to bit 0 of reg_addr 5 sets the lock, which reads back in bit 0 of that address. A later write of 0 does not clear it; only reset does.
- R4: Once locked, writes to range registers 0 to 4 are ignored, and both the readback and the enforcement keep the old values.
- R5: While unlocked, every access is allowed and raises no error.
- R6: When locked, an access of kind write (acc_kind 01) or erase (acc_kind 10) is denied if its page lies in a range whose write enable is set.
- R7: When locked, a read (acc_kind 00) is denied if its page lies in a range whose read enable is set. The write enable does not affect reads, and the read enable does not affect writes.
- R8: The lower bound covers address offset 0x000 of its page and the upper bound covers offset 0xFFF of its page, both inclusive. Address bits 31:25 are ignored.
- R9: A range whose lower page is above its upper page matches no address.
- R10: An access of kind 11 is always allowed.
- R11: res_valid, res_allow and err_pulse give the verdict on the cycle after acc_valid is sampled. res_valid is high only on that cycle.
- R12: err_pulse is high for exactly that one cycle for each denied access, and the error flag is set at the same edge. The flag reads in bit 0 of reg_addr 6 and is cleared by writing 1 to that bit; writing 0 leaves it. If a denial and a clear land on the same edge, the flag ends up set.
- R13: Writes to reg_addr 7 have no effect, and that address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| acc_valid | input | 1 | Access presented this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10 erase, 11 other |
| acc_addr | input | 32 | Access byte address |
| res_valid | output | 1 | Verdict valid |
| res_allow | output | 1 | Access allowed |
| err_pulse | output | 1 | One-cycle pulse on a denial |
| err_flag | output | 1 | Sticky error flag |

## Verification
The bench checks addresses one byte on each side of every page bound. A design that treated the upper bound as exclusive, or compared raw addresses without widening the limits, would let through an access at offset 0xFFF of the last page or refuse one just below the first page. It sets address bits above bit 24 and builds a range with its lower page above its upper page. A careless comparator would then deny on alias addresses or treat the inverted range as a wrap-around. It also tries to rewrite a range and to clear the lock after lock-down, and it sends a denial and an error clear in the same cycle, where a wrong priority would lose the error.

// File: rtl/frg_pkg.sv
package frg_pkg;
  localparam int WORD_W  = 32;
  localparam int LIM_W   = 13;
  localparam int OFF_W   = 12;
  localparam int FLA_W   = LIM_W + OFF_W;
  localparam int WPE_BIT = 31;
  localparam int RPE_BIT = 15;
  localparam int UP_LSB  = 16;
  localparam int LO_LSB  = 0;
  // reserved bits 30:29 and 14:13 are masked off on write
  localparam logic [WORD_W-1:0] RNG_WMASK = 32'h9FFF_9FFF;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_ERASE = 2'b10,
    ACC_OTHER = 2'b11
  } acc_kind_e;

  function automatic logic [LIM_W-1:0] lo_page(input logic [WORD_W-1:0] w);
    return w[LO_LSB +: LIM_W];
  endfunction

  function automatic logic [LIM_W-1:0] hi_page(input logic [WORD_W-1:0] w);
    return w[UP_LSB +: LIM_W];
  endfunction

  function automatic logic [LIM_W-1:0] addr_page(input logic [WORD_W-1:0] a);
    return a[OFF_W +: LIM_W];
  endfunction

  // page compare is equivalent to widening lower with zeros, upper with ones
  function automatic logic range_blocks(input logic [WORD_W-1:0] w,
                                        input logic [WORD_W-1:0] a,
                                        input acc_kind_e k);
    logic in_span;
    logic en;
    in_span = (addr_page(a) >= lo_page(w)) && (addr_page(a) <= hi_page(w));
    case (k)
      ACC_READ:            en = w[RPE_BIT];
      ACC_WRITE, ACC_ERASE: en = w[WPE_BIT];
      default:             en = 1'b0;
    endcase
    return in_span && en;
  endfunction
endpackage

// File: rtl/frg_regs.sv
module frg_regs
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int REG_AW     = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_wr,
  input  logic [REG_AW-1:0]                   reg_addr,
  input  logic [WORD_W-1:0]                   reg_wdata,
  input  logic                                err_flag,
  output logic [WORD_W-1:0]                   reg_rdata,
  output logic                                locked,
  output logic [NUM_RANGES-1:0][WORD_W-1:0]   rng,
  output logic                                clr_err
);
  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(NUM_RANGES);
  localparam logic [REG_AW-1:0] STAT_ADDR = REG_AW'(NUM_RANGES + 1);

  logic [NUM_RANGES-1:0][WORD_W-1:0] rng_q;
  logic                              lock_q;
  logic [NUM_RANGES-1:0]             range_wr_ev;
  logic                              lock_set_ev;

  assign lock_set_ev = reg_wr && (reg_addr == CTRL_ADDR) && reg_wdata[0];
  assign clr_err     = reg_wr && (reg_addr == STAT_ADDR) && reg_wdata[0];

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
    assign range_wr_ev[i] = reg_wr && !lock_q && (reg_addr == REG_AW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)              rng_q[i] <= '0;
      else if (range_wr_ev[i]) rng_q[i] <= reg_wdata & RNG_WMASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           lock_q <= 1'b0;
    else if (lock_set_ev) lock_q <= 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (reg_addr == REG_AW'(i)) reg_rdata = rng_q[i];
    if (reg_addr == CTRL_ADDR) reg_rdata = {{(WORD_W-1){1'b0}}, lock_q};
    if (reg_addr == STAT_ADDR) reg_rdata = {{(WORD_W-1){1'b0}}, err_flag};
  end

  assign locked = lock_q;
  assign rng    = rng_q;

  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(rng_q));
endmodule

// File: rtl/frg_match.sv
module frg_match
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5
) (
  input  logic                              locked,
  input  logic [NUM_RANGES-1:0][WORD_W-1:0] rng,
  input  logic [1:0]                        acc_kind,
  input  logic [WORD_W-1:0]                 acc_addr,
  output logic                              deny
);
  logic [NUM_RANGES-1:0] hit_vec;

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
    assign hit_vec[i] = range_blocks(rng[i], acc_addr, acc_kind_e'(acc_kind));
  end

  assign deny = locked && (|hit_vec);
endmodule

// File: rtl/frg_status.sv
module frg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic deny,
  input  logic clr_err,
  output logic res_valid,
  output logic res_allow,
  output logic err_pulse,
  output logic err_flag
);
  logic deny_ev;
  logic valid_q, allow_q, pulse_q, flag_q;

  assign deny_ev = acc_valid && deny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      allow_q <= 1'b1;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      valid_q <= acc_valid;
      allow_q <= !deny_ev;
      pulse_q <= deny_ev;
      if (deny_ev)      flag_q <= 1'b1;
      else if (clr_err) flag_q <= 1'b0;
    end
  end

  assign res_valid = valid_q;
  assign res_allow = allow_q;
  assign err_pulse = pulse_q;
  assign err_flag  = flag_q;

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);
  a_r11_valid_only_then: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);
  a_r12_pulse_is_denial: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (res_valid && !res_allow));
  a_r12_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_flag);
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_flag);
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import frg_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int REG_AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [31:0]       acc_addr,
  output logic              res_valid,
  output logic              res_allow,
  output logic              err_pulse,
  output logic              err_flag
);
  logic                              locked;
  logic [NUM_RANGES-1:0][WORD_W-1:0] rng;
  logic                              clr_err;
  logic                              deny;

  frg_regs #(.NUM_RANGES(NUM_RANGES), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .err_flag(err_flag), .reg_rdata(reg_rdata),
    .locked(locked), .rng(rng), .clr_err(clr_err)
  );

  frg_match #(.NUM_RANGES(NUM_RANGES)) u_match (
    .locked(locked), .rng(rng), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .deny(deny)
  );

  frg_status u_status (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .deny(deny),
    .clr_err(clr_err), .res_valid(res_valid), .res_allow(res_allow),
    .err_pulse(err_pulse), .err_flag(err_flag)
  );

  a_r5_open_before_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !locked) |=> res_allow);
  a_r10_other_kind_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'b11) |=> res_allow);
endmodule

// File: tb/tb_flash_range_guard.sv
`timescale 1ns/1ps
module tb_flash_range_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [31:0] acc_addr = '0;
  logic        res_valid, res_allow, err_pulse, err_flag;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] sh [5];
  logic        sh_lock = 1'b0;

  always #10 clk = ~clk;

  flash_range_guard dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .res_valid(res_valid),
    .res_allow(res_allow), .err_pulse(err_pulse), .err_flag(err_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte-address form of the rule: lower widened with 0x000, upper with 0xFFF
  function automatic logic model_deny(input logic [1:0] k, input logic [31:0] a);
    logic [24:0] fa, lo_a, hi_a;
    logic d;
    d = 1'b0;
    fa = a[24:0];
    if (sh_lock) begin
      for (int i = 0; i < 5; i++) begin
        lo_a = {sh[i][12:0], 12'h000};
        hi_a = {sh[i][28:16], 12'hFFF};
        if (fa >= lo_a && fa <= hi_a) begin
          if (k == 2'b00 && sh[i][15]) d = 1'b1;
          if ((k == 2'b01 || k == 2'b10) && sh[i][31]) d = 1'b1;
        end
      end
    end
    return d;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a < 3'd5 && !sh_lock) sh[a] = d & 32'h9FFF_9FFF;
    if (a == 3'd5 && d[0]) sh_lock = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic access(input string req, input logic [1:0] k, input logic [31:0] a);
    logic exp_deny;
    exp_deny = model_deny(k, a);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " valid"}, {31'b0, res_valid}, 32'd1);
    chk({req, " allow"}, {31'b0, res_allow}, {31'b0, !exp_deny});
    chk({req, " pulse"}, {31'b0, err_pulse}, {31'b0, exp_deny});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 5; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 res_valid", {31'b0, res_valid}, 0);
    chk("R1 err_pulse", {31'b0, err_pulse}, 0);
    chk("R1 err_flag", {31'b0, err_flag}, 0);
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), v);
      chk("R1 reg", v, 0);
    end

    // R2 field layout and reserved bits
    wr(3'd4, 32'h7FFF_6000);
    rd(3'd4, v); chk("R2 reserved", v, 32'h1FFF_0000);
    wr(3'd0, 32'h8000_0000 | (32'h01F << 16) | 32'h010);  // WP pages 0x10..0x1F
    wr(3'd1, (32'h100 << 16) | 32'h8000 | 32'h100);       // RP page 0x100
    wr(3'd2, 32'h8000_8000 | (32'h1FFF << 16) | 32'h1FFE); // both, top pages
    wr(3'd3, 32'h8000_8000 | (32'h040 << 16) | 32'h050);  // inverted
    wr(3'd4, (32'h200 << 16) | 32'h8000 | 32'h200);       // RP page 0x200
    rd(3'd0, v); chk("R2 r0", v, 32'h801F_0010);
    rd(3'd1, v); chk("R2 r1", v, 32'h0100_8100);
    rd(3'd2, v); chk("R2 r2", v, 32'h9FFF_9FFE);

    // R13 unused address
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, v); chk("R13 unused", v, 0);
    rd(3'd0, v); chk("R13 no side effect", v, 32'h801F_0010);

    // R5 open before lock
    access("R5 write in r0", 2'b01, 32'h0001_0000);
    access("R5 read in r1", 2'b00, 32'h0010_0000);
    for (int n = 0; n < 20; n++) access("R5 random", 2'($urandom_range(0, 3)), $urandom());
    chk("R5 no flag", {31'b0, err_flag}, 0);

    // R3 lock
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R3 lock set", v, 1);
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R3 lock stays", v, 1);

    // R4 frozen ranges
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R4 frozen", v, 32'h801F_0010);
    access("R4 still enforced", 2'b01, 32'h0001_8000);

    // R6 / R8 boundaries of r0
    access("R8 below lower", 2'b01, 32'h0000_FFFF);
    access("R8 lower edge", 2'b01, 32'h0001_0000);
    access("R8 upper edge", 2'b01, 32'h0001_FFFF);
    access("R8 above upper", 2'b01, 32'h0002_0000);
    access("R8 high bits ignored", 2'b01, 32'hFE01_0000);
    access("R6 erase", 2'b10, 32'h0001_5000);
    access("R7 read not write-guarded", 2'b00, 32'h0001_5000);
    access("R7 read denied", 2'b00, 32'h0010_0000);
    access("R7 read denied top", 2'b00, 32'h0010_0FFF);
    access("R7 write not read-guarded", 2'b01, 32'h0010_0000);
    access("R6 top page", 2'b10, 32'h01FF_FFFF);
    access("R9 inverted", 2'b01, 32'h0004_5000);
    access("R9 inverted lo", 2'b01, 32'h0005_0000);
    access("R10 other kind", 2'b11, 32'h0001_0000);

    // R11 / R12 one-cycle result
    access("R12 deny", 2'b01, 32'h0001_0000);
    @(negedge clk);
    chk("R11 valid drops", {31'b0, res_valid}, 0);
    chk("R12 pulse drops", {31'b0, err_pulse}, 0);
    chk("R12 flag sticky", {31'b0, err_flag}, 1);
    wr(3'd6, 32'h0);
    rd(3'd6, v); chk("R12 write 0 keeps", v, 1);
    wr(3'd6, 32'h1);
    rd(3'd6, v); chk("R12 clear", v, 0);
    // R12 denial and clear together: set wins
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h1;
    acc_valid = 1'b1; acc_kind = 2'b01; acc_addr = 32'h0001_0000;
    @(negedge clk);
    reg_wr = 1'b0; acc_valid = 1'b0;
    chk("R12 set wins", {31'b0, err_flag}, 1);

    // random near range bounds
    for (int n = 0; n < 400; n++) begin
      int idx;
      logic [12:0] pg;
      logic [31:0] a;
      logic [1:0] k;
      idx = $urandom_range(0, 4);
      pg = (($urandom_range(0, 1) == 0) ? sh[idx][12:0] : sh[idx][28:16])
           + 13'($urandom_range(0, 4)) - 13'd2;
      a = $urandom();
      a[24:12] = pg;
      k = 2'($urandom_range(0, 3));
      access((k == 2'b00) ? "R7 random" : "R6 random", k, a);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule